// File: doc/BRIEF.md
# Bank-Switching Memory Map Controller

This block steers CPU memory cycles in an 8-bit system with a 64 KB address space in which two windows can be overlaid. The low window (0x0000–0x0FFF) holds either the boot monitor ROM or DRAM. The high window (0xD000–0xFFFF) holds either video RAM plus the memory-mapped peripherals, or DRAM, or nothing at all while it is locked out. All other addresses always reach DRAM.

Software changes the map with an I/O write to one of seven consecutive ports starting at 0xE0. Only the low byte of the I/O address names the port, and the data bus is not used. The block keeps three internal flags: low window holds ROM, high window holds devices, and high window locked. These flags are updated at the clock edge that samples the I/O write. From them the block drives active-low chip selects for DRAM (row strobe), ROM, peripherals and video RAM. It also drives an active-low CPU wait request while video RAM is accessed outside display blanking.

Top module: `mmc_overlay_ctrl`

## Requirements
- R1: After reset the low window selects ROM, the high window selects video RAM/peripherals, and the lock-out is off.
- R2: An I/O write to port 0xE0 maps the low window to DRAM. A write to port 0xE2 maps it back to ROM. Neither write changes the high window or the lock.
- R3: An I/O write to port 0xE1 maps the high window to DRAM. A write to port 0xE3 maps it to video RAM/peripherals. Neither write changes the low window or the lock.
- R4: An I/O write to port 0xE4 maps ROM low and devices high, and it also clears any lock-out.
- R5: An I/O write to port 0xE5 locks the high window, so that no select goes low for any address in 0xD000–0xFFFF. Writes to 0xE1 or 0xE3 while locked do not end the lock.
- R6: An I/O write to port 0xE6 ends the lock-out. The high window then shows the mapping last chosen by 0xE1, 0xE3 or 0xE4, including a choice made during the lock.
- R7: With devices mapped high, 0xD000–0xDFFF asserts vram_cs_n and 0xE000–0xE00F asserts per_cs_n. Every other high-window address asserts no select.
- R8: Addresses 0x1000–0xCFFF always assert dram_ras_n, whatever the map state.
- R9: A select goes low only while mreq_n is low and rd_n or wr_n is low, and never more than one at a time. I/O cycles assert no select.
- R10: cpu_wait_n is low exactly while vram_cs_n is low and disp_blank is low (active display).
- R11: The following change no flag: I/O writes to ports outside 0xE0–0xE6 (such as 0xDF and 0xE7), and I/O reads of any port. The upper address byte of an I/O write is ignored.
- R12: A map change takes effect from the rising clock edge at which iorq_n and wr_n are sampled low. It governs the memory cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| disp_blank | input | 1 | High during display blanking |
| dram_ras_n | output | 1 | DRAM row strobe, active low |
| rom_cs_n | output | 1 | Monitor ROM select, active low |
| per_cs_n | output | 1 | Memory-mapped peripheral select, active low |
| vram_cs_n | output | 1 | Video RAM select, active low |
| cpu_wait_n | output | 1 | CPU wait request, active low |

## Verification
The assertions assume that the CPU never drives mreq_n and iorq_n low in the same cycle. They also assume that the address and strobes are steady across a clock edge, so that an I/O write is seen at a sampling edge. The stimulus changes every input only on the falling clock edge and holds it for a full cycle. Each bus cycle is either a memory access or an I/O access, never both, and the strobes are released between operations. Map commands are interleaved with reads and writes across all three windows under both blanking levels, so that each flag combination is observed at the select outputs.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_LOW_DRAM  = 3'd1,
        CMD_HIGH_DRAM = 3'd2,
        CMD_LOW_ROM   = 3'd3,
        CMD_HIGH_DEV  = 3'd4,
        CMD_BOTH_DEV  = 3'd5,
        CMD_LOCK      = 3'd6,
        CMD_UNLOCK    = 3'd7
    } mmc_cmd_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_DRAM = 3'd1,
        TGT_ROM  = 3'd2,
        TGT_VRAM = 3'd3,
        TGT_PER  = 3'd4
    } mmc_target_e;

    typedef struct packed {
        logic low_rom;    // 1: low window holds ROM
        logic high_dev;   // 1: high window holds video RAM / peripherals
        logic high_lock;  // 1: high window answers nothing
    } map_state_t;

    localparam map_state_t MAP_RESET = '{low_rom: 1'b1, high_dev: 1'b1, high_lock: 1'b0};

    localparam int NUM_CMD_PORTS = 7;

endpackage

// File: rtl/mmc_port_decode.sv
module mmc_port_decode
    import mmc_pkg::*;
#(
    parameter int          PORT_W    = 8,
    parameter logic [7:0]  PORT_BASE = 8'hE0
) (
    input  logic [PORT_W-1:0] io_port,
    input  logic              iorq_n,
    input  logic              wr_n,
    output mmc_cmd_e          cmd
);

    logic [PORT_W-1:0] offset;
    logic              io_write;

    always_comb begin
        offset   = io_port - PORT_W'(PORT_BASE);
        io_write = !iorq_n && !wr_n;
        cmd      = CMD_NONE;
        if (io_write && (offset < PORT_W'(NUM_CMD_PORTS))) begin
            case (offset[2:0])
                3'd0:    cmd = CMD_LOW_DRAM;
                3'd1:    cmd = CMD_HIGH_DRAM;
                3'd2:    cmd = CMD_LOW_ROM;
                3'd3:    cmd = CMD_HIGH_DEV;
                3'd4:    cmd = CMD_BOTH_DEV;
                3'd5:    cmd = CMD_LOCK;
                3'd6:    cmd = CMD_UNLOCK;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mmc_map_state.sv
module mmc_map_state
    import mmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mmc_cmd_e   cmd,
    output map_state_t state_q
);

    map_state_t state_d;

    always_comb begin
        state_d = state_q;
        case (cmd)
            CMD_LOW_DRAM:  state_d.low_rom   = 1'b0;
            CMD_HIGH_DRAM: state_d.high_dev  = 1'b0;
            CMD_LOW_ROM:   state_d.low_rom   = 1'b1;
            CMD_HIGH_DEV:  state_d.high_dev  = 1'b1;
            CMD_BOTH_DEV: begin
                state_d.low_rom   = 1'b1;
                state_d.high_dev  = 1'b1;
                state_d.high_lock = 1'b0;
            end
            CMD_LOCK:      state_d.high_lock = 1'b1;
            CMD_UNLOCK:    state_d.high_lock = 1'b0;
            default:       state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_RESET;
        else        state_q <= state_d;
    end

    // R5: a lock command always leaves the window locked
    a_r5_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOCK) |=> state_q.high_lock);

    // R5: high-window remaps do not end a lock
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.high_lock && (cmd == CMD_HIGH_DRAM || cmd == CMD_HIGH_DEV)) |=> state_q.high_lock);

    // R6: unlock clears the lock and keeps the chosen high mapping
    a_r6_unlock_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_UNLOCK) |=> (!state_q.high_lock && $stable(state_q.high_dev)));

    // R4: combined command lands on the reset map
    a_r4_both_dev: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BOTH_DEV) |=> (state_q == MAP_RESET));

    // R11: no command, no change
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE) |=> $stable(state_q));

endmodule

// File: rtl/mmc_addr_decode.sv
module mmc_addr_decode
    import mmc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h1000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] VRAM_LAST = 16'hDFFF,
    parameter logic [ADDR_W-1:0] PER_BASE  = 16'hE000,
    parameter logic [ADDR_W-1:0] PER_LAST  = 16'hE00F
) (
    input  logic [ADDR_W-1:0] addr,
    input  map_state_t        map,
    output mmc_target_e       target
);

    logic in_low;
    logic in_high;
    logic in_vram;
    logic in_per;

    always_comb begin
        in_low  = (addr < LOW_LIMIT);
        in_high = (addr >= HIGH_BASE);
        in_vram = in_high && (addr <= VRAM_LAST);
        in_per  = (addr >= PER_BASE) && (addr <= PER_LAST);

        target = TGT_DRAM;
        if (in_low) begin
            target = map.low_rom ? TGT_ROM : TGT_DRAM;
        end else if (in_high) begin
            if (map.high_lock)      target = TGT_NONE;
            else if (!map.high_dev) target = TGT_DRAM;
            else if (in_vram)       target = TGT_VRAM;
            else if (in_per)        target = TGT_PER;
            else                    target = TGT_NONE;
        end
    end

endmodule

// File: rtl/mmc_overlay_ctrl.sv
module mmc_overlay_ctrl
    import mmc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [7:0]        PORT_BASE = 8'hE0,
    parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h1000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] VRAM_LAST = 16'hDFFF,
    parameter logic [ADDR_W-1:0] PER_BASE  = 16'hE000,
    parameter logic [ADDR_W-1:0] PER_LAST  = 16'hE00F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              disp_blank,
    output logic              dram_ras_n,
    output logic              rom_cs_n,
    output logic              per_cs_n,
    output logic              vram_cs_n,
    output logic              cpu_wait_n
);

    localparam int PORT_W  = 8;
    localparam int NUM_SEL = 4;   // index i selects target i+1

    mmc_cmd_e     cmd;
    map_state_t   map_q;
    mmc_target_e  target;
    logic         mem_cycle;
    logic [NUM_SEL-1:0] sel_n;

    mmc_port_decode #(
        .PORT_W    (PORT_W),
        .PORT_BASE (PORT_BASE)
    ) u_port (
        .io_port (cpu_addr[PORT_W-1:0]),
        .iorq_n  (iorq_n),
        .wr_n    (wr_n),
        .cmd     (cmd)
    );

    mmc_map_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .state_q (map_q)
    );

    mmc_addr_decode #(
        .ADDR_W    (ADDR_W),
        .LOW_LIMIT (LOW_LIMIT),
        .HIGH_BASE (HIGH_BASE),
        .VRAM_LAST (VRAM_LAST),
        .PER_BASE  (PER_BASE),
        .PER_LAST  (PER_LAST)
    ) u_addr (
        .addr   (cpu_addr),
        .map    (map_q),
        .target (target)
    );

    assign mem_cycle = !mreq_n && (!rd_n || !wr_n);

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign sel_n[i] = !(mem_cycle && (target == mmc_target_e'(i + 1)));
    end

    assign dram_ras_n = sel_n[0];
    assign rom_cs_n   = sel_n[1];
    assign vram_cs_n  = sel_n[2];
    assign per_cs_n   = sel_n[3];
    assign cpu_wait_n = !(!vram_cs_n && !disp_blank);

    // R9: at most one select at a time
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~dram_ras_n, ~rom_cs_n, ~per_cs_n, ~vram_cs_n}));

    // R9: no select outside a memory read or write
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || (rd_n && wr_n)) |-> (dram_ras_n && rom_cs_n && per_cs_n && vram_cs_n));

    // R10: wait only for video RAM during active display
    a_r10_wait_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wait_n |-> (!vram_cs_n && !disp_blank));

    // R8: middle addresses go to DRAM on any memory cycle
    a_r8_middle_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cycle && cpu_addr >= LOW_LIMIT && cpu_addr < HIGH_BASE) |-> !dram_ras_n);

    // R7: video RAM select only inside its range
    a_r7_vram_range: assert property (@(posedge clk) disable iff (!rst_n)
        !vram_cs_n |-> (cpu_addr >= HIGH_BASE && cpu_addr <= VRAM_LAST));

    // R5: locked high window answers nothing
    a_r5_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q.high_lock && cpu_addr >= HIGH_BASE) |-> (dram_ras_n && per_cs_n && vram_cs_n));

endmodule

// File: tb/tb_mmc_overlay_ctrl.sv
`timescale 1ns/1ps
module tb_mmc_overlay_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        disp_blank = 1'b1;
    logic        dram_ras_n, rom_cs_n, per_cs_n, vram_cs_n, cpu_wait_n;

    always #10 clk = ~clk;   // 50 MHz

    mmc_overlay_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .disp_blank(disp_blank),
        .dram_ras_n(dram_ras_n), .rom_cs_n(rom_cs_n), .per_cs_n(per_cs_n),
        .vram_cs_n(vram_cs_n), .cpu_wait_n(cpu_wait_n)
    );

    typedef struct {
        logic [4:0]  exp;   // {ras, rom, per, vram, wait}, active low
        logic [15:0] addr;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];
    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // independent map model
    bit m_low_rom = 1'b1, m_high_dev = 1'b1, m_lock = 1'b0;

    function automatic logic [4:0] expect_sel(logic [15:0] a, bit act, bit blank);
        logic [4:0] v;
        v = 5'b11111;
        if (!act) return v;
        if (a < 16'h1000) begin
            if (m_low_rom) v[3] = 1'b0; else v[4] = 1'b0;
        end else if (a >= 16'hD000) begin
            if (!m_lock) begin
                if (!m_high_dev) v[4] = 1'b0;
                else if (a <= 16'hDFFF) begin
                    v[1] = 1'b0;
                    if (!blank) v[0] = 1'b0;
                end else if (a <= 16'hE00F) v[2] = 1'b0;
            end
        end else v[4] = 1'b0;
        return v;
    endfunction

    task automatic model_port(logic [7:0] p);
        case (p)
            8'hE0: m_low_rom = 1'b0;
            8'hE1: m_high_dev = 1'b0;
            8'hE2: m_low_rom = 1'b1;
            8'hE3: m_high_dev = 1'b1;
            8'hE4: begin m_low_rom = 1'b1; m_high_dev = 1'b1; m_lock = 1'b0; end
            8'hE5: m_lock = 1'b1;
            8'hE6: m_lock = 1'b0;
            default: ;
        endcase
    endtask

    task automatic mem_acc(logic [15:0] a, bit is_rd, bit blank, string tag);
        sb_item_t it;
        @(negedge clk);
        cpu_addr = a; mreq_n = 1'b0; iorq_n = 1'b1;
        rd_n = !is_rd; wr_n = is_rd; disp_blank = blank;
        it.exp = expect_sel(a, 1'b1, blank); it.addr = a; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic mem_strobeless(logic [15:0] a, string tag);
        sb_item_t it;
        @(negedge clk);
        cpu_addr = a; mreq_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        it.exp = 5'b11111; it.addr = a; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic io_op(logic [15:0] a, bit is_wr, string tag);
        sb_item_t it;
        @(negedge clk);
        cpu_addr = a; mreq_n = 1'b1; iorq_n = 1'b0;
        rd_n = is_wr; wr_n = !is_wr;
        it.exp = 5'b11111; it.addr = a; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
        if (is_wr) model_port(a[7:0]);
    endtask

    task automatic idle_cycle();
        sb_item_t it;
        @(negedge clk);
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        it.exp = 5'b11111; it.addr = cpu_addr; it.tag = "R9 idle";
        sb.push_back(it);
        @(posedge clk);
    endtask

    // monitor: compare one item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                sb_item_t it;
                logic [4:0] got;
                it  = sb.pop_front();
                got = {dram_ras_n, rom_cs_n, per_cs_n, vram_cs_n, cpu_wait_n};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.addr, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset map
        mem_acc(16'h0000, 1, 1, "R1 low rom");
        mem_acc(16'h0FFF, 1, 1, "R1 low rom top");
        mem_acc(16'hD000, 1, 1, "R1 vram");
        mem_acc(16'hE000, 1, 1, "R1 peripheral");
        mem_acc(16'h1000, 0, 1, "R8 first dram");

        // R9 strobes
        idle_cycle();
        mem_strobeless(16'h5000, "R9 no strobe");
        mem_acc(16'h5000, 0, 0, "R9 write dram");

        // R10 wait
        mem_acc(16'hD123, 1, 0, "R10 vram active read");
        mem_acc(16'hDFFF, 0, 0, "R10 vram active write");
        mem_acc(16'hDFFF, 0, 1, "R10 vram blank");
        mem_acc(16'hE005, 1, 0, "R10 per no wait");

        // R7 subdivision
        mem_acc(16'hE00F, 1, 1, "R7 per top");
        mem_acc(16'hE010, 1, 1, "R7 gap");
        mem_acc(16'hF000, 1, 1, "R7 gap high");
        mem_acc(16'hFFFF, 1, 1, "R7 last");

        // R2 and R12
        io_op(16'h00E0, 1, "R9 io write quiet");
        mem_acc(16'h0000, 1, 1, "R12 R2 low dram next cycle");
        mem_acc(16'h0800, 0, 1, "R2 low dram");
        mem_acc(16'hD400, 1, 1, "R2 high untouched");

        // R11 ignored ports / reads / upper byte
        io_op(16'h00E7, 1, "R11 port e7");
        io_op(16'h00DF, 1, "R11 port df");
        io_op(16'h00E2, 0, "R11 io read");
        mem_acc(16'h0010, 1, 1, "R11 low still dram");
        mem_acc(16'hD000, 1, 1, "R11 high still vram");
        io_op(16'h12E2, 1, "R11 upper byte");
        mem_acc(16'h0010, 1, 1, "R11 R2 low rom");

        // R3
        io_op(16'h00E1, 1, "R3 cmd");
        mem_acc(16'hD000, 1, 0, "R3 high dram");
        mem_acc(16'hE008, 0, 0, "R3 high dram per");
        mem_acc(16'hFFFF, 1, 0, "R3 high dram top");
        mem_acc(16'h0000, 1, 0, "R3 low untouched");
        io_op(16'h00E3, 1, "R3 cmd back");
        mem_acc(16'hD800, 1, 0, "R3 vram back");

        // R5 lock
        io_op(16'h00E5, 1, "R5 cmd");
        mem_acc(16'hD000, 1, 1, "R5 locked vram");
        mem_acc(16'hE000, 1, 1, "R5 locked per");
        mem_acc(16'hFFFF, 0, 1, "R5 locked top");
        mem_acc(16'h0000, 1, 1, "R5 low untouched");
        mem_acc(16'h8000, 1, 1, "R5 middle dram");
        io_op(16'h00E1, 1, "R5 remap while locked");
        mem_acc(16'hD000, 1, 1, "R5 still locked");

        // R6 restore
        io_op(16'h00E6, 1, "R6 cmd");
        mem_acc(16'hD000, 1, 1, "R6 restored dram");
        io_op(16'h00E3, 1, "R6 devices");
        io_op(16'h00E5, 1, "R6 lock");
        io_op(16'h00E6, 1, "R6 unlock");
        mem_acc(16'hD000, 1, 0, "R6 restored vram");
        mem_acc(16'hE001, 1, 0, "R6 restored per");

        // R4
        io_op(16'h00E0, 1, "R4 pre low");
        io_op(16'h00E1, 1, "R4 pre high");
        io_op(16'h00E5, 1, "R4 pre lock");
        io_op(16'h00E4, 1, "R4 cmd");
        mem_acc(16'h0000, 1, 1, "R4 low rom");
        mem_acc(16'hD000, 1, 1, "R4 vram");
        mem_acc(16'hE00F, 1, 1, "R4 per");

        // R8 sweep across map states
        for (int s = 0; s < 3; s++) begin
            if (s == 1) io_op(16'h00E0, 1, "R8 state low dram");
            if (s == 2) io_op(16'h00E5, 1, "R8 state lock");
            for (int a = 16'h1000; a < 16'hD000; a += 16'h0FFF)
                mem_acc(16'(a), s[0], 0, "R8 middle");
            mem_acc(16'hCFFF, 1, 0, "R8 middle top");
        end

        idle_cycle();
        @(posedge clk); #8;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule